// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register File

This block holds the software-visible state of one bank of general-purpose pins and drives the pad buffers from it. A 32-bit register bus reaches six word locations. Two are half-word masked ports: in a write to one of them, the top 16 bits say which of the 16 data bits below are to be left alone. Software can therefore set or clear any group of output pins in one write, with no read-modify-write sequence and no race against other writers of the same bank. The other locations are a full output data word, a read-only word of synchronized pad levels, a direction word and an output-enable word.

Bus commands use a valid/ready handshake (`cmd_*`). Every read produces one response on a valid/ready channel (`rsp_*`); writes produce none. One response can be outstanding. While it is held because `rsp_ready` is low, `cmd_ready` is low, so no further command is accepted. A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. A response is consumed on a rising edge where `rsp_valid` and `rsp_ready` are both high. A new read may be accepted on the same edge that consumes the previous response.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset the output, direction and output-enable words are all zero, so `pad_out` and `pad_oe` are zero and no response is pending.
- R2: A write to byte address 0x000 changes output pins 0–15. For each bit i in 15:0, the pin takes `wdata[i]` only if `wdata[16+i]` is 0; if `wdata[16+i]` is 1 the pin keeps its old value. Pins 16–31 are not changed.
- R3: A write to byte address 0x004 does the same for pins 16–31, with `wdata[15:0]` as the data and `wdata[31:16]` as the inhibit bits. Pins 0–15 are not changed.
- R4: Byte address 0x040 reads and writes all 32 output bits directly. `pad_out` equals the output word after each write.
- R5: Byte address 0x060 is read-only and returns the pad levels after two synchronizer flops. A level applied before the rising edge on which a read is accepted becomes visible in a read accepted two or more edges later. Writes to it change nothing.
- R6: Byte address 0x204 (direction, 1 = output) and byte address 0x208 (output enable) are both full-width read/write words.
- R7: `pad_oe[i]` is 1 only when both direction bit i and output-enable bit i are 1.
- R8: A read of 0x000 or 0x004 returns the current output half-word for that port in bits 15:0 and zero in bits 31:16.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `cmd_ready` is low, and `rsp_valid` and `rsp_rdata` hold their values.
- R10: A read of any other address returns zero. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this edge if valid |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Byte address within the bank |
| cmd_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | DW | Read data |
| pad_in | input | DW | Asynchronous pad levels |
| pad_out | output | DW | Output value to pad buffers |
| pad_oe | output | DW | Drive enable to pad buffers |

## Verification
A write shows on `pad_out` and `pad_oe` right after the rising edge that accepts it. A read response is valid after the rising edge that accepts the read. A pad level change is returned by the input word only for a read accepted two edges after the level was captured. The bench drives all inputs on falling edges and samples outputs on the falling edge that follows the accepting rising edge. For the synchronizer it reads once right after a pin change and expects the old level, then reads again later and expects the new level. For back-pressure it holds `rsp_ready` low over several falling edges while checking that `cmd_ready` stays low, that the response is unchanged and that the queued write has not taken effect.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DW_DEF     = 32;
  localparam int unsigned ADDR_W_DEF = 10;

  // register offsets; the masked-port pair order (low half, high half) matters
  localparam int unsigned OFS_MASK_LO = 'h000;
  localparam int unsigned OFS_MASK_HI = 'h004;
  localparam int unsigned OFS_OUT     = 'h040;
  localparam int unsigned OFS_IN      = 'h060;
  localparam int unsigned OFS_DIR     = 'h204;
  localparam int unsigned OFS_OEN     = 'h208;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MLO,
    SEL_MHI,
    SEL_OUT,
    SEL_IN,
    SEL_DIR,
    SEL_OEN
  } reg_sel_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] A_MLO = ADDR_W'(OFS_MASK_LO);
  localparam logic [ADDR_W-1:0] A_MHI = ADDR_W'(OFS_MASK_HI);
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(OFS_IN);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_OEN = ADDR_W'(OFS_OEN);

  always_comb begin
    unique case (addr)
      A_MLO:   sel = SEL_MLO;
      A_MHI:   sel = SEL_MHI;
      A_OUT:   sel = SEL_OUT;
      A_IN:    sel = SEL_IN;
      A_DIR:   sel = SEL_DIR;
      A_OEN:   sel = SEL_OEN;
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= pad_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

  // age counter so the two-cycle history check only looks at post-reset samples
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync_o == $past(pad_i, 2))); // R5
endmodule

// File: rtl/gpio_bank_core.sv
module gpio_bank_core
  import gpio_bank_pkg::*;
#(
  parameter int unsigned DW = DW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] oen_q
);
  localparam int unsigned HW    = DW / 2;
  localparam int unsigned LANES = 2;

  logic [DW-1:0] out_masked;
  logic [LANES-1:0] lane_hit;

  // one masked lane per half; data in wdata[HW-1:0], inhibit in wdata[DW-1:HW]
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam reg_sel_e LANE_SEL = (l == 0) ? SEL_MLO : SEL_MHI;
    logic [HW-1:0] cur;
    logic [HW-1:0] keep;
    assign lane_hit[l] = wr_en && (sel == LANE_SEL);
    assign cur  = out_q[l*HW +: HW];
    assign keep = wdata[DW-1:HW];
    assign out_masked[l*HW +: HW] = lane_hit[l] ?
      ((cur & keep) | (wdata[HW-1:0] & ~keep)) : cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      oen_q <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_MLO, SEL_MHI: out_q <= out_masked;
        SEL_OUT:          out_q <= wdata;
        SEL_DIR:          dir_q <= wdata;
        SEL_OEN:          oen_q <= wdata;
        default:          ;
      endcase
    end
  end

  AST_LO_PORT_SPARES_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_MLO) |=> (out_q[DW-1:HW] == $past(out_q[DW-1:HW]))); // R2
  AST_HI_PORT_SPARES_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_MHI) |=> (out_q[HW-1:0] == $past(out_q[HW-1:0]))); // R3
  AST_FULL_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_MLO || sel == SEL_MHI) && (&wdata[DW-1:HW])) |=> $stable(out_q)); // R2
  AST_DEAD_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_NONE || sel == SEL_IN)) |=>
      ($stable(out_q) && $stable(dir_q) && $stable(oen_q))); // R10
endmodule

// File: rtl/gpio_rsp_stage.sv
module gpio_rsp_stage #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R9
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned DW     = DW_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DW-1:0]     cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [DW-1:0]     pad_in,
  output logic [DW-1:0]     pad_out,
  output logic [DW-1:0]     pad_oe
);
  localparam int unsigned HW = DW / 2;

  reg_sel_e      sel;
  logic          fire;
  logic          wr_en;
  logic          rd_en;
  logic [DW-1:0] out_q, dir_q, oen_q, in_sync;
  logic [DW-1:0] rd_word;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign wr_en     = fire && cmd_we;
  assign rd_en     = fire && !cmd_we;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (cmd_addr),
    .sel  (sel)
  );

  gpio_in_sync #(.W(DW)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_i  (pad_in),
    .sync_o (in_sync)
  );

  gpio_bank_core #(.DW(DW)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .sel   (sel),
    .wdata (cmd_wdata),
    .out_q (out_q),
    .dir_q (dir_q),
    .oen_q (oen_q)
  );

  always_comb begin
    unique case (sel)
      SEL_MLO: rd_word = {{HW{1'b0}}, out_q[HW-1:0]};
      SEL_MHI: rd_word = {{HW{1'b0}}, out_q[DW-1:HW]};
      SEL_OUT: rd_word = out_q;
      SEL_IN:  rd_word = in_sync;
      SEL_DIR: rd_word = dir_q;
      SEL_OEN: rd_word = oen_q;
      default: rd_word = '0;
    endcase
  end

  gpio_rsp_stage #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_en),
    .load_data (rd_word),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q & oen_q;

  AST_DIR_CLEAR_KILLS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DIR && cmd_wdata == '0) |=> (pad_oe == '0)); // R7
  AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && cmd_valid) |=> $stable(pad_out)); // R9
endmodule

// File: tb/gpio_bank_regs_tb_top.sv
module gpio_bank_regs_tb_top;
  localparam int DW = 32;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_we = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;
  logic [DW-1:0] pad_in = '0;
  logic [DW-1:0] pad_out;
  logic [DW-1:0] pad_oe;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] out_m = '0;

  always #5 clk = ~clk;

  gpio_bank_regs #(.DW(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_we = 1'b1; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rsp_ready = 1'b1;
    cmd_valid = 1'b1; cmd_we = 1'b0; cmd_addr = a;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    d = rsp_rdata;
    if (!rsp_valid) chk("R9 rsp_valid after read", {31'b0, rsp_valid}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    logic [DW-1:0] held;
    logic [DW-1:0] pats [4];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h0F0F_3C3C;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, '0);
    rd(10'h040, r); chk("R1 out word", r, '0);
    rd(10'h204, r); chk("R1 dir word", r, '0);
    rd(10'h208, r); chk("R1 oen word", r, '0);

    // R2 / R3 masked-port sweep
    for (int l = 0; l < 2; l++) begin
      for (int i = 0; i < 24; i++) begin
        logic [15:0] m, d, cur, nxt;
        m = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'(i * 16'h2F5B + l * 16'h0101);
        d = 16'(i * 16'h7A31) ^ 16'hC3A5;
        cur = (l == 0) ? out_m[15:0] : out_m[31:16];
        nxt = (cur & m) | (d & ~m);
        if (l == 0) out_m[15:0] = nxt; else out_m[31:16] = nxt;
        wr((l == 0) ? 10'h000 : 10'h004, {m, d});
        if (l == 0) chk("R2 lower masked write", pad_out, out_m);
        else        chk("R3 upper masked write", pad_out, out_m);
        if (i % 6 == 5) begin
          rd((l == 0) ? 10'h000 : 10'h004, r);
          chk("R8 masked port read", r, {16'h0000, nxt});
          rd(10'h040, r);
          chk("R4 out word after masked", r, out_m);
        end
      end
    end

    // R4 full output word
    for (int i = 0; i < 4; i++) begin
      out_m = pats[i] ^ 32'h1357_9BDF;
      wr(10'h040, out_m);
      chk("R4 pad_out full write", pad_out, out_m);
      rd(10'h040, r);
      chk("R4 full readback", r, out_m);
    end

    // R6 / R7 direction and output-enable sweep
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        wr(10'h204, pats[a]);
        wr(10'h208, pats[b]);
        chk("R7 pad_oe", pad_oe, pats[a] & pats[b]);
        if (b == a) begin
          rd(10'h204, r); chk("R6 dir readback", r, pats[a]);
          rd(10'h208, r); chk("R6 oen readback", r, pats[b]);
        end
      end
    end

    // R5 synchronizer latency and read-only word
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    repeat (4) @(negedge clk);
    rd(10'h060, r); chk("R5 input settled", r, 32'hDEAD_BEEF);
    @(negedge clk); pad_in = 32'h0123_4567;
    rd(10'h060, r); chk("R5 input not yet visible", r, 32'hDEAD_BEEF);
    rd(10'h060, r); chk("R5 input visible later", r, 32'h0123_4567);
    wr(10'h060, 32'hFFFF_FFFF);
    chk("R5 write to input word pad_out", pad_out, out_m);
    rd(10'h060, r); chk("R5 write to input word ignored", r, 32'h0123_4567);

    // R10 unmapped addresses
    wr(10'h100, 32'hFFFF_FFFF);
    chk("R10 unmapped write pad_out", pad_out, out_m);
    rd(10'h204, r); chk("R10 unmapped write dir", r, pats[3]);
    rd(10'h208, r); chk("R10 unmapped write oen", r, pats[3]);
    rd(10'h00C, r); chk("R10 unmapped read", r, '0);
    rd(10'h3FC, r); chk("R10 unmapped read top", r, '0);

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_valid = 1'b1; cmd_we = 1'b0; cmd_addr = 10'h040;
    @(negedge clk);
    held = rsp_rdata;
    chk("R9 response data", held, out_m);
    cmd_we = 1'b1; cmd_addr = 10'h040; cmd_wdata = 32'h55AA_00FF;
    for (int k = 0; k < 3; k++) begin
      chk("R9 cmd_ready low", {31'b0, cmd_ready}, '0);
      chk("R9 rsp held", rsp_rdata, held);
      chk("R9 queued write not applied", pad_out, out_m);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_we = 1'b0;
    out_m = 32'h55AA_00FF;
    chk("R9 write accepted on release", pad_out, out_m);
    chk("R9 response consumed", {31'b0, rsp_valid}, '0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule